// File: doc/BRIEF.md
# Multidrop serial receiver with address filtering

This block receives asynchronous serial frames from a single line that is oversampled sixteen times per bit. It supports two frame shapes. The short shape is a start bit, eight data bits sent least significant first, and a stop bit. The long shape adds a ninth data bit between the eighth data bit and the stop bit. Each received frame can raise a receive flag. A framing-error flag records a missing stop bit. Both flags stay set until a clear strobe drops them.

On a shared multidrop line, one station sends frames to many listeners. A listener can turn on address filtering. While filtering is on, a frame counts as an address frame only when its ninth bit (or, in the short shape, its stop bit) is 1. Such a frame raises the receive flag only when its byte equals the listener's own address or the broadcast address. All other frames pass without disturbing the flag or the output registers. The cycle in which the flag rises depends on whether framing-error detection is enabled. A mode-select value of zero stands for a synchronous shift mode that this block does not serve. In that mode the receiver ignores the line.

Top module: `mpuart_rx`

## Requirements
- R1: After reset, riFlag, feFlag, rxData and rxNinth are all 0.
- R2: With modeSel = 1, a frame is 0 (start), eight data bits LSB first, then the stop bit. Each bit lasts 16 tick16 pulses, and the byte appears on rxData when riFlag rises.
- R3: Each data, ninth and stop bit is decided by a 2-of-3 vote over its samples 7, 8 and 9, counting the first tick that sees the start bit low as sample 0. One disturbed sample among them does not change the result.
- R4: A start bit that reads high at its sample 8 is dropped and reception returns to idle. Flags and output registers are unchanged.
- R5: riFlag rises in the clock after the vote of the stop bit when feEnable = 1, or when the short shape is used with mpEnable = 1. Otherwise it rises after the vote of the last data bit: D7 in the short shape, D8 in the long shape.
- R6: With modeSel = 2 or 3, a ninth bit follows D7 and is loaded into rxNinth. With modeSel = 1, rxNinth is loaded with the voted stop bit when the flag rises at the stop bit, and with 0 otherwise.
- R7: feFlag is set when the voted stop bit is 0 while feEnable = 1. A stop bit of 0 with feEnable = 0 leaves feFlag at 0.
- R8: feFlag is sticky. Later frames with a valid stop bit do not clear it. Only feClear or reset clears it.
- R9: riFlag stays set until riClear. rxData and rxNinth change only in the clock where riFlag is raised. If a raise and riClear fall in the same clock, the raise wins.
- R10: With mpEnable = 1 in the long shape, riFlag rises only for a frame whose ninth bit is 1 and whose byte equals ownAddr or bcastAddr.
- R11: With mpEnable = 1 in the short shape, the stop bit serves as the ninth bit. A matching address raises riFlag only if the stop bit is 1.
- R12: With modeSel = 0, line activity has no effect on riFlag, feFlag, rxData or rxNinth, whether mpEnable is set or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| rxLine | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-clock pulse at 16 times the bit rate |
| modeSel | input | 2 | 0 shift (unused), 1 short shape, 2 or 3 long shape |
| feEnable | input | 1 | Framing-error detection enable |
| mpEnable | input | 1 | Address filtering enable |
| ownAddr | input | 8 | Own station address |
| bcastAddr | input | 8 | Broadcast address |
| riClear | input | 1 | Clears riFlag |
| feClear | input | 1 | Clears feFlag |
| rxData | output | 8 | Last accepted byte |
| rxNinth | output | 1 | Ninth bit of the last accepted frame |
| riFlag | output | 1 | Receive flag |
| feFlag | output | 1 | Sticky framing-error flag |

## Verification
The majority vote and the start-bit glitch filter are the hardest conditions to reach from the ports. A clean frame never shows them. They need the line to change between individual oversample ticks. The bench therefore drives the line one oversample tick at a time. It can flip a single sample inside the 7-to-9 window of every data bit, and it can pull the line low for only a few ticks so that the start bit is gone by its middle sample. Address frames that differ only in the ninth bit or in the stop bit exercise the filter in both frame shapes.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rxState_t;

  // Strobes from control to datapath, all valid for one clock
  typedef struct packed {
    logic histEn;     // an oversample tick: shift the sample history
    logic shiftData;  // vote point of a data bit
    logic takeNinth;  // vote point of the ninth bit
    logic takeStop;   // vote point of the stop bit
    logic evalNow;    // point where the frame is judged and the flag may rise
  } rxStrobe_t;

endpackage

// File: rtl/mpuart_rx_ctrl.sv
module mpuart_rx_ctrl
  import mpuart_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxS,
  input  logic [1:0] modeSel,
  input  logic       feEnable,
  input  logic       mpEnable,
  output rxStrobe_t  strb
);

  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int MID   = OSR / 2;
  localparam logic [CNT_W-1:0] MID_C  = CNT_W'(MID);
  localparam logic [CNT_W-1:0] VOTE_C = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] TOP_C  = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] LAST_C = IDX_W'(DATA_W - 1);

  rxState_t         state;
  logic [CNT_W-1:0] sampCnt;
  logic [IDX_W-1:0] bitIdx;

  logic nine, active, voteTick, stopEval, lastData;

  assign nine   = modeSel[1];
  assign active = |modeSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sampCnt <= '0;
      bitIdx  <= '0;
    end else if (!active) begin
      state   <= ST_IDLE;
      sampCnt <= '0;
    end else if (tick) begin
      if (state == ST_IDLE) begin
        if (!rxS) begin
          state   <= ST_START;
          sampCnt <= CNT_W'(1);
        end
      end else if (state == ST_START && sampCnt == MID_C && rxS) begin
        state <= ST_IDLE;
      end else if (state == ST_STOP && sampCnt == VOTE_C) begin
        state <= ST_IDLE;
      end else begin
        sampCnt <= (sampCnt == TOP_C) ? '0 : sampCnt + CNT_W'(1);
        if (sampCnt == TOP_C) begin
          unique case (state)
            ST_START: begin
              state  <= ST_DATA;
              bitIdx <= '0;
            end
            ST_DATA: begin
              if (bitIdx == LAST_C) state <= nine ? ST_NINTH : ST_STOP;
              else                  bitIdx <= bitIdx + IDX_W'(1);
            end
            ST_NINTH: state <= ST_STOP;
            default:  state <= state;
          endcase
        end
      end
    end
  end

  assign voteTick = tick && active && (sampCnt == VOTE_C);
  assign stopEval = feEnable || (!nine && mpEnable);
  assign lastData = (bitIdx == LAST_C);

  always_comb begin
    strb.histEn    = tick;
    strb.shiftData = voteTick && (state == ST_DATA);
    strb.takeNinth = voteTick && (state == ST_NINTH);
    strb.takeStop  = voteTick && (state == ST_STOP);
    if (stopEval)  strb.evalNow = strb.takeStop;
    else if (nine) strb.evalNow = strb.takeNinth;
    else           strb.evalNow = strb.shiftData && lastData;
  end

endmodule

// File: rtl/mpuart_rx_dp.sv
module mpuart_rx_dp
  import mpuart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  rxStrobe_t         strb,
  input  logic              nine,
  input  logic              feEnable,
  input  logic              mpEnable,
  input  logic [DATA_W-1:0] ownAddr,
  input  logic [DATA_W-1:0] bcastAddr,
  input  logic              riClear,
  input  logic              feClear,
  output logic              rxS,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              riFlag,
  output logic              feFlag
);

  logic [SYNC_N-1:0] syncReg;
  logic [1:0]        hist;
  logic [DATA_W-1:0] shiftReg, candByte;
  logic              ninthReg, candNinth, vote, addrHit, accept;

  // line synchronizer, idle level 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg <= '1;
    else begin
      syncReg[0] <= rxLine;
      for (int i = 1; i < SYNC_N; i++) syncReg[i] <= syncReg[i-1];
    end
  end
  assign rxS = syncReg[SYNC_N-1];

  // hist[1] = sample 7, hist[0] = sample 8, rxS = sample 9 at the vote tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           hist <= 2'b11;
    else if (strb.histEn) hist <= {hist[0], rxS};
  end
  assign vote = (hist[1] & hist[0]) | (hist[1] & rxS) | (hist[0] & rxS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ninthReg <= 1'b0;
    end else begin
      if (strb.shiftData) shiftReg <= {vote, shiftReg[DATA_W-1:1]};
      if (strb.takeNinth) ninthReg <= vote;
    end
  end

  always_comb begin
    candByte = strb.shiftData ? {vote, shiftReg[DATA_W-1:1]} : shiftReg;
    if (nine) candNinth = strb.takeNinth ? vote : ninthReg;
    else      candNinth = strb.takeStop & vote;
    addrHit = (candByte == ownAddr) || (candByte == bcastAddr);
    accept  = !mpEnable || (candNinth && addrHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxNinth <= 1'b0;
      riFlag  <= 1'b0;
      feFlag  <= 1'b0;
    end else begin
      if (strb.evalNow && accept) begin
        rxData  <= candByte;
        rxNinth <= candNinth;
        riFlag  <= 1'b1;
      end else if (riClear) begin
        riFlag  <= 1'b0;
      end
      if (strb.takeStop && feEnable && !vote) feFlag <= 1'b1;
      else if (feClear)                       feFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mpuart_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              tick16,
  input  logic [1:0]        modeSel,
  input  logic              feEnable,
  input  logic              mpEnable,
  input  logic [DATA_W-1:0] ownAddr,
  input  logic [DATA_W-1:0] bcastAddr,
  input  logic              riClear,
  input  logic              feClear,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              riFlag,
  output logic              feFlag
);

  rxStrobe_t strb;
  logic      rxS;

  mpuart_rx_ctrl #(.OSR(OSR), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick16), .rxS(rxS), .modeSel(modeSel),
    .feEnable(feEnable), .mpEnable(mpEnable), .strb(strb)
  );

  mpuart_rx_dp #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strb(strb), .nine(modeSel[1]),
    .feEnable(feEnable), .mpEnable(mpEnable), .ownAddr(ownAddr),
    .bcastAddr(bcastAddr), .riClear(riClear), .feClear(feClear), .rxS(rxS),
    .rxData(rxData), .rxNinth(rxNinth), .riFlag(riFlag), .feFlag(feFlag)
  );

endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk
  import mpuart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              feEnable,
  input logic              mpEnable,
  input logic [DATA_W-1:0] ownAddr,
  input logic [DATA_W-1:0] bcastAddr,
  input logic              riClear,
  input logic              feClear,
  input logic [DATA_W-1:0] rxData,
  input logic              rxNinth,
  input logic              riFlag,
  input logic              feFlag,
  input rxStrobe_t         strb
);

  // R8
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    feFlag && !feClear |=> feFlag);

  // R9
  ri_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    riFlag && !riClear |=> riFlag);

  // R9
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.evalNow |=> $stable(rxData) && $stable(rxNinth));

  // R7
  fe_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(feFlag) |-> $past(strb.takeStop && feEnable));

  // R5
  ri_at_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(riFlag) && $past(feEnable) |-> $past(strb.takeStop));

  // R10
  addr_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(riFlag) && $past(mpEnable) |->
      rxNinth && (rxData == $past(ownAddr) || rxData == $past(bcastAddr)));

  // R12
  shift_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00) && $past(modeSel == 2'b00) |-> !$rose(riFlag));

endmodule

bind mpuart_rx mpuart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .feEnable(feEnable),
  .mpEnable(mpEnable), .ownAddr(ownAddr), .bcastAddr(bcastAddr),
  .riClear(riClear), .feClear(feClear), .rxData(rxData), .rxNinth(rxNinth),
  .riFlag(riFlag), .feFlag(feFlag), .strb(strb)
);

// File: tb/tb_mpuart_rx.sv
`timescale 1ns/1ps
module tb_mpuart_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       tick16 = 1'b0;
  logic [1:0] modeSel = 2'd1;
  logic       feEnable = 1'b0, mpEnable = 1'b0;
  logic [7:0] ownAddr = 8'h42, bcastAddr = 8'hFF;
  logic       riClear = 1'b0, feClear = 1'b0;
  logic [7:0] rxData;
  logic       rxNinth, riFlag, feFlag;

  int errors = 0, checks = 0;
  int tickNum = 0, divCnt = 0;
  bit compareOn = 1'b0, finished = 1'b0;
  string curReq = "R1";

  typedef struct {int atTick; bit isFe; logic [7:0] d; logic n;} ev_t;
  ev_t evq[$];
  logic expRi = 0, expFe = 0, expNinth = 0;
  logic [7:0] expData = 0;
  bit doRi, doFe;
  logic [7:0] pendD;
  logic pendN;

  always #2.5 clk = ~clk;

  mpuart_rx dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .tick16(tick16), .modeSel(modeSel),
    .feEnable(feEnable), .mpEnable(mpEnable), .ownAddr(ownAddr),
    .bcastAddr(bcastAddr), .riClear(riClear), .feClear(feClear),
    .rxData(rxData), .rxNinth(rxNinth), .riFlag(riFlag), .feFlag(feFlag)
  );

  // oversample tick: one clock in four
  always @(negedge clk) begin
    divCnt = (divCnt + 1) % 4;
    tick16 = (divCnt == 0);
  end

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    doRi = 0; doFe = 0; pendD = expData; pendN = expNinth;
    if (!rstN) begin
      expRi = 0; expFe = 0; expData = 0; expNinth = 0;
    end else begin
      if (tick16) begin
        tickNum = tickNum + 1;
        foreach (evq[i]) if (evq[i].atTick == tickNum) begin
          if (evq[i].isFe) doFe = 1;
          else begin doRi = 1; pendD = evq[i].d; pendN = evq[i].n; end
        end
      end
      if (riClear) expRi = 0;
      if (doRi) begin expRi = 1; expData = pendD; expNinth = pendN; end
      if (feClear) expFe = 0;
      if (doFe) expFe = 1;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rstN && compareOn) begin
      checks++;
      if (riFlag !== expRi || feFlag !== expFe || rxData !== expData || rxNinth !== expNinth) begin
        errors++;
        $display("FAIL %s cycle compare: actual ri=%0b fe=%0b data=%02h ninth=%0b expected ri=%0b fe=%0b data=%02h ninth=%0b",
                 curReq, riFlag, feFlag, rxData, rxNinth, expRi, expFe, expData, expNinth);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitTick();
    int n = tickNum;
    do @(negedge clk); while (tickNum == n);
  endtask

  task automatic idleTicks(input int n);
    rxLine = 1'b1;
    repeat (n) waitTick();
  endtask

  // Sends one frame one oversample tick at a time; flipSample >= 0 inverts
  // that sample of every data bit. The expected flags are derived from R5-R12.
  task automatic sendFrame(input logic [7:0] b, input logic ninthV, input logic stopV,
                           input int flipSample);
    bit nine = modeSel[1];
    int nBits = nine ? 11 : 10;
    int stopIdx = nBits - 1;
    int lastIdx = nine ? 9 : 8;
    bit stopEval = feEnable || (!nine && mpEnable);
    int evalIdx = stopEval ? stopIdx : lastIdx;
    logic seenNinth = nine ? ninthV : (stopEval ? stopV : 1'b0);
    bit accept = !mpEnable || (seenNinth && (b == ownAddr || b == bcastAddr));
    logic [10:0] bits;
    int t0;
    bits = '1;
    bits[0] = 1'b0;
    for (int k = 0; k < 8; k++) bits[k+1] = b[k];
    if (nine) bits[9] = ninthV;
    bits[stopIdx] = stopV;
    waitTick();
    t0 = tickNum;
    if (modeSel != 2'd0) begin
      if (accept) evq.push_back('{t0 + 1 + 16*evalIdx + 9, 1'b0, b, seenNinth});
      if (feEnable && !stopV) evq.push_back('{t0 + 1 + 16*stopIdx + 9, 1'b1, 8'h0, 1'b0});
    end
    for (int i = 0; i < 16*nBits; i++) begin
      logic v = bits[i/16];
      if (i > 0) waitTick();
      if (flipSample >= 0 && (i/16) >= 1 && (i/16) <= 8 && (i%16) == flipSample) v = ~v;
      rxLine = v;
    end
    waitTick();
    idleTicks(40);
  endtask

  task automatic pulseRiClear();
    @(negedge clk); riClear = 1'b1;
    @(negedge clk); riClear = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseFeClear();
    @(negedge clk); feClear = 1'b1;
    @(negedge clk); feClear = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 riFlag", riFlag, 0);
    check("R1 feFlag", feFlag, 0);
    check("R1 rxData", rxData, 0);
    check("R1 rxNinth", rxNinth, 0);
    compareOn = 1'b1;
    idleTicks(4);

    // R2 short shape, R5 flag at D7 with detection off
    curReq = "R2/R5";
    sendFrame(8'hA5, 1'b0, 1'b1, -1);
    check("R2 rxData", rxData, 8'hA5);
    check("R2 riFlag", riFlag, 1);
    check("R6 rxNinth short shape flag at D7", rxNinth, 0);
    curReq = "R9";
    pulseRiClear();
    check("R9 riFlag cleared", riFlag, 0);

    // R6 long shape
    curReq = "R6/R5";
    modeSel = 2'd2;
    sendFrame(8'h3C, 1'b1, 1'b1, -1);
    check("R6 rxData", rxData, 8'h3C);
    check("R6 rxNinth", rxNinth, 1);
    pulseRiClear();
    modeSel = 2'd3;
    sendFrame(8'hC4, 1'b0, 1'b1, -1);
    check("R6 rxNinth zero", rxNinth, 0);
    pulseRiClear();

    // R7 / R8 framing error
    curReq = "R7";
    modeSel = 2'd1; feEnable = 1'b1;
    sendFrame(8'h5A, 1'b0, 1'b0, -1);
    check("R7 feFlag set", feFlag, 1);
    check("R6 rxNinth holds stop bit", rxNinth, 0);
    pulseRiClear();
    curReq = "R8";
    sendFrame(8'h11, 1'b0, 1'b1, -1);
    check("R8 feFlag sticky", feFlag, 1);
    check("R6 rxNinth stop bit 1", rxNinth, 1);
    pulseFeClear();
    check("R8 feFlag cleared", feFlag, 0);
    pulseRiClear();
    curReq = "R7";
    feEnable = 1'b0;
    sendFrame(8'h66, 1'b0, 1'b0, -1);
    check("R7 no FE when disabled", feFlag, 0);
    check("R7 data still taken", rxData, 8'h66);
    pulseRiClear();

    // R3 majority vote
    curReq = "R3";
    sendFrame(8'hC3, 1'b0, 1'b1, 8);
    check("R3 sample 8 disturbed", rxData, 8'hC3);
    pulseRiClear();
    sendFrame(8'h29, 1'b0, 1'b1, 7);
    check("R3 sample 7 disturbed", rxData, 8'h29);
    pulseRiClear();

    // R4 start glitch
    curReq = "R4";
    waitTick(); rxLine = 1'b0;
    repeat (4) waitTick();
    idleTicks(30);
    check("R4 riFlag after glitch", riFlag, 0);
    check("R4 rxData after glitch", rxData, 8'h29);
    sendFrame(8'h81, 1'b0, 1'b1, -1);
    check("R4 receiver recovers", rxData, 8'h81);
    pulseRiClear();

    // R10 long shape filtering
    curReq = "R10";
    modeSel = 2'd2; mpEnable = 1'b1;
    sendFrame(8'h42, 1'b0, 1'b1, -1);
    check("R10 data frame ignored", riFlag, 0);
    check("R9 rxData untouched", rxData, 8'h81);
    sendFrame(8'h17, 1'b1, 1'b1, -1);
    check("R10 foreign address ignored", riFlag, 0);
    sendFrame(8'h42, 1'b1, 1'b1, -1);
    check("R10 own address", riFlag, 1);
    check("R10 own address data", rxData, 8'h42);
    pulseRiClear();
    sendFrame(8'hFF, 1'b1, 1'b1, -1);
    check("R10 broadcast", riFlag, 1);
    pulseRiClear();

    // R11 short shape filtering, stop as ninth bit
    curReq = "R11";
    modeSel = 2'd1;
    sendFrame(8'h42, 1'b0, 1'b1, -1);
    check("R11 match with stop 1", riFlag, 1);
    check("R11 ninth from stop", rxNinth, 1);
    pulseRiClear();
    sendFrame(8'hFF, 1'b0, 1'b0, -1);
    check("R11 match with stop 0", riFlag, 0);

    // R12 shift mode
    curReq = "R12";
    modeSel = 2'd0;
    sendFrame(8'h42, 1'b0, 1'b1, -1);
    check("R12 mp on, shift mode", riFlag, 0);
    mpEnable = 1'b0;
    sendFrame(8'h24, 1'b0, 1'b1, -1);
    check("R12 mp off, shift mode", riFlag, 0);
    check("R12 rxData untouched", rxData, 8'h42);

    // R9 raise wins over clear held high
    curReq = "R9";
    modeSel = 2'd1;
    @(negedge clk); riClear = 1'b1;
    sendFrame(8'h9E, 1'b0, 1'b1, -1);
    @(negedge clk); riClear = 1'b0;
    check("R9 data loaded under clear", rxData, 8'h9E);
    check("R9 flag cleared afterwards", riFlag, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule